// File: doc/BRIEF.md
# Interpolating Sine Oscillator

This block is a numerically controlled sine oscillator for audio synthesis. A 32-bit phase register advances by a programmable tuning step once per sample request, so the output frequency scales linearly with the tuning word. The upper phase bits select a position in a 1024-point sine table held in on-chip ROM. The bits beneath them give a fractional position, which a cubic (Catmull-Rom) kernel uses to blend four neighbouring table points instead of truncating to the nearest one.

The host raises a one-cycle sample strobe at the audio rate. The block reads its four table points one per cycle from a single-port ROM and then runs a five-stage arithmetic pipeline. It presents a signed 16-bit sample together with a one-cycle valid pulse a fixed ten cycles after the strobe. The output side has no ready input and no back-pressure: the consumer must take the sample in the cycle where valid is high. The value then stays on the output until the next valid pulse. On the input side, a strobe that arrives while a sample is still being computed is dropped. The only exception is the cycle in which that sample completes.

Top module: `sine_nco_interp`

## Requirements
- R1: While reset is low and after it is released, `smp_valid` is 0 and `smp_out` is 0. Reset clears the phase register and the held tuning step to zero, so the first two samples after reset are both taken at phase 0.
- R2: A strobe is accepted when no sample is in progress, or when it is seen at the same clock edge that raises the previous sample's valid pulse. In cycle terms, it is accepted 10 or more cycles after the previous accepted strobe. Any strobe sooner than that is ignored entirely: it produces no sample, does not advance the phase and captures no tuning word.
- R3: At an accepted strobe the sample is computed from the current phase P. The phase then becomes P plus the step held from the previous accepted strobe (modulo 2^32), and `tune_word` is captured as the new step.
- R4: Changes on `tune_word` in cycles without an accepted strobe have no effect on any later sample.
- R5: Table entry k (0..1023) equals round(32767*sin(2*pi*k/1024)), with halves rounded away from zero. The index i is phase bits [31:22]; the fraction t is phase bits [21:6], taken as unsigned Q0.16.
- R6: The four points are q0..q3 = table[(i-1) mod 1024], table[i], table[(i+1) mod 1024], table[(i+2) mod 1024]. The index wraps in both directions.
- R7: With a = 3q1 - 3q2 + q3 - q0, b = 2q0 - 5q1 + 4q2 - q3, c = q2 - q0 and d = 2q1, the block evaluates three floor steps: h1 = floor(a*t/2^16), h2 = floor((b+h1)*t/2^16) and h3 = floor((c+h2)*t/2^16). The output is floor((d+h3+1)/2), saturated to -32768..32767.
- R8: `smp_valid` is high for exactly one cycle. It rises at the 10th rising edge after the edge that accepted the strobe. `smp_out` changes only together with that pulse.
- R9: When t is zero the output equals table[i] exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | Sample request strobe |
| tune_word | input | 32 | Phase step, captured only at an accepted strobe |
| smp_out | output | 16 | Signed interpolated sample |
| smp_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
Two events can fall at the same clock edge: the final stage of one sample, which raises valid and frees the sequencer, and the acceptance of the next strobe. The scoreboard provokes this by spacing strobes exactly ten cycles apart. It judges the result by requiring both samples to appear with correct values at their own ten-cycle latency, and by requiring that the phase advanced on the second strobe. Strobes spaced closer than ten cycles are also sent. For these, the bench confirms that no extra pulse appears and that the next accepted sample's phase shows neither the dropped step nor its tuning word.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  localparam int NCO_ACC_W      = 32;
  localparam int NCO_IDX_W      = 10;
  localparam int NCO_FRAC_W     = 16;
  localparam int NCO_SAMPLE_W   = 16;
  localparam int NCO_TAPS       = 4;
  localparam int NCO_INTERP_LAT = 5;
  localparam int NCO_AMPLITUDE  = 32767;
  localparam real NCO_PI        = 3.141592653589793;

  // Rounded sine value for table slot k, halves away from zero.
  function automatic int sine_entry(int k, int depth, int amp);
    real x;
    x = real'(amp) * $sin(2.0 * NCO_PI * real'(k) / real'(depth));
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(0.5 - x);
  endfunction
endpackage

// File: rtl/nco_sine_rom.sv
`timescale 1ns/1ps
module nco_sine_rom
  import nco_pkg::*;
#(
  parameter int ADDR_W = NCO_IDX_W,
  parameter int DATA_W = NCO_SAMPLE_W,
  parameter int AMP    = NCO_AMPLITUDE
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Contents computed at elaboration; the array maps to a ROM.
  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = DATA_W'(sine_entry(k, DEPTH, AMP));
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/nco_phase_accum.sv
`timescale 1ns/1ps
module nco_phase_accum
  import nco_pkg::*;
#(
  parameter int ACC_W   = NCO_ACC_W,
  parameter int PHASE_W = NCO_IDX_W + NCO_FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [ACC_W-1:0]   tune_in,
  output logic [PHASE_W-1:0] phase_hi
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step_q;

  // The step captured at one accepted strobe is applied at the next one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      step_q <= '0;
    end else if (take) begin
      acc_q  <= acc_q + step_q;
      step_q <= tune_in;
    end
  end

  assign phase_hi = acc_q[ACC_W-1 -: PHASE_W];

  // R4: phase and step never move without an accepted strobe
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(acc_q) && $stable(step_q)));
endmodule

// File: rtl/nco_tap_sequencer.sv
`timescale 1ns/1ps
module nco_tap_sequencer
  import nco_pkg::*;
#(
  parameter int IDX_W      = NCO_IDX_W,
  parameter int FRAC_W     = NCO_FRAC_W,
  parameter int SAMPLE_W   = NCO_SAMPLE_W,
  parameter int INTERP_LAT = NCO_INTERP_LAT
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               strobe,
  input  logic [IDX_W+FRAC_W-1:0]            phase_hi,
  output logic                               take,
  output logic [IDX_W-1:0]                   rom_addr,
  input  logic [SAMPLE_W-1:0]                rom_data,
  output logic [NCO_TAPS-1:0][SAMPLE_W-1:0]  taps,
  output logic [FRAC_W-1:0]                  frac,
  output logic                               taps_valid
);
  localparam int LAST  = NCO_TAPS + INTERP_LAT;
  localparam int CNT_W = $clog2(LAST + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             fin;

  assign fin  = busy_q && (cnt_q == CNT_W'(LAST));
  assign take = strobe && (!busy_q || fin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      frac   <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= phase_hi[IDX_W+FRAC_W-1 -: IDX_W];
      frac   <= phase_hi[FRAC_W-1:0];
    end else if (fin) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // Point k is addressed in step k, starting one slot below the index.
  assign rom_addr = idx_q + IDX_W'(cnt_q) - IDX_W'(1);

  // ROM data is one cycle late, so point k lands in step k+1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps       <= '0;
      taps_valid <= 1'b0;
    end else begin
      for (int k = 0; k < NCO_TAPS; k++) begin
        if (busy_q && cnt_q == CNT_W'(k + 1)) taps[k] <= rom_data;
      end
      taps_valid <= busy_q && (cnt_q == CNT_W'(NCO_TAPS));
    end
  end

  // R6: the index stays put while its points are being fetched
  a_r6_index_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> $stable(idx_q));

  // R2: a sample in progress is never abandoned before it finishes
  a_r2_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> busy_q);
endmodule

// File: rtl/nco_cubic_interp.sv
`timescale 1ns/1ps
module nco_cubic_interp
  import nco_pkg::*;
#(
  parameter int SAMPLE_W = NCO_SAMPLE_W,
  parameter int FRAC_W   = NCO_FRAC_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [NCO_TAPS-1:0][SAMPLE_W-1:0] taps,
  input  logic [FRAC_W-1:0]                 frac,
  output logic signed [SAMPLE_W-1:0]        out_sample,
  output logic                              out_valid
);
  localparam int CW   = SAMPLE_W + 5;
  localparam int PW   = CW + FRAC_W + 1;
  localparam int SMAX = (1 << (SAMPLE_W - 1)) - 1;
  localparam int SMIN = -(1 << (SAMPLE_W - 1));

  logic signed [CW-1:0] q0, q1, q2, q3;
  assign q0 = CW'($signed(taps[0]));
  assign q1 = CW'($signed(taps[1]));
  assign q2 = CW'($signed(taps[2]));
  assign q3 = CW'($signed(taps[3]));

  // Stage 1: polynomial coefficients.
  logic signed [CW-1:0] s1_a, s1_b, s1_c, s1_d;
  logic [FRAC_W-1:0]    s1_t;
  // Stage 2..4: Horner steps.
  logic signed [CW-1:0] s2_h, s2_b, s2_c, s2_d;
  logic [FRAC_W-1:0]    s2_t;
  logic signed [CW-1:0] s3_h, s3_c, s3_d;
  logic [FRAC_W-1:0]    s3_t;
  logic signed [CW-1:0] s4_h, s4_d;
  logic [NCO_INTERP_LAT-1:0] vpipe;

  logic signed [FRAC_W:0] t1_s, t2_s, t3_s;
  assign t1_s = {1'b0, s1_t};
  assign t2_s = {1'b0, s2_t};
  assign t3_s = {1'b0, s3_t};

  logic signed [PW-1:0] m1, m2, m3;
  logic signed [CW-1:0] bh, ch;
  assign bh = s2_b + s2_h;
  assign ch = s3_c + s3_h;
  assign m1 = s1_a * t1_s;
  assign m2 = bh * t2_s;
  assign m3 = ch * t3_s;

  logic signed [CW:0] y_sum, y_half;
  logic signed [SAMPLE_W-1:0] y_sat;
  assign y_sum  = (CW+1)'(s4_d) + (CW+1)'(s4_h) + (CW+1)'(1);
  assign y_half = y_sum >>> 1;

  always_comb begin
    if (y_half > (CW+1)'(SMAX))      y_sat = SAMPLE_W'(SMAX);
    else if (y_half < (CW+1)'(SMIN)) y_sat = SAMPLE_W'(SMIN);
    else                             y_sat = SAMPLE_W'(y_half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_a <= '0; s1_b <= '0; s1_c <= '0; s1_d <= '0; s1_t <= '0;
      s2_h <= '0; s2_b <= '0; s2_c <= '0; s2_d <= '0; s2_t <= '0;
      s3_h <= '0; s3_c <= '0; s3_d <= '0; s3_t <= '0;
      s4_h <= '0; s4_d <= '0;
      out_sample <= '0;
      vpipe      <= '0;
    end else begin
      vpipe <= {vpipe[NCO_INTERP_LAT-2:0], in_valid};
      if (in_valid) begin
        s1_a <= CW'(q3 - q0 + 3 * (q1 - q2));
        s1_b <= CW'(2 * q0 - 5 * q1 + 4 * q2 - q3);
        s1_c <= q2 - q0;
        s1_d <= CW'(2 * q1);
        s1_t <= frac;
      end
      if (vpipe[0]) begin
        s2_h <= CW'(m1 >>> FRAC_W);
        s2_b <= s1_b; s2_c <= s1_c; s2_d <= s1_d; s2_t <= s1_t;
      end
      if (vpipe[1]) begin
        s3_h <= CW'(m2 >>> FRAC_W);
        s3_c <= s2_c; s3_d <= s2_d; s3_t <= s2_t;
      end
      if (vpipe[2]) begin
        s4_h <= CW'(m3 >>> FRAC_W);
        s4_d <= s3_d;
      end
      if (vpipe[3]) out_sample <= y_sat;
    end
  end

  assign out_valid = vpipe[NCO_INTERP_LAT-1];

  // R8: a result leaves exactly five cycles after its points arrive
  a_r8_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 5));

  // R9: a zero fraction reproduces the centre point
  a_r9_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(frac == '0, 5)) |-> (out_sample == $signed($past(taps[1], 5))));
endmodule

// File: rtl/sine_nco_interp.sv
`timescale 1ns/1ps
module sine_nco_interp
  import nco_pkg::*;
#(
  parameter int ACC_W    = NCO_ACC_W,
  parameter int IDX_W    = NCO_IDX_W,
  parameter int FRAC_W   = NCO_FRAC_W,
  parameter int SAMPLE_W = NCO_SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_stb,
  input  logic [ACC_W-1:0]           tune_word,
  output logic signed [SAMPLE_W-1:0] smp_out,
  output logic                       smp_valid
);
  localparam int PHASE_W = IDX_W + FRAC_W;

  logic                              take;
  logic [PHASE_W-1:0]                phase_hi;
  logic [IDX_W-1:0]                  rom_addr;
  logic [SAMPLE_W-1:0]               rom_data;
  logic [NCO_TAPS-1:0][SAMPLE_W-1:0] taps;
  logic [FRAC_W-1:0]                 frac;
  logic                              taps_valid;

  nco_phase_accum #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .take(take), .tune_in(tune_word), .phase_hi(phase_hi)
  );

  nco_tap_sequencer #(
    .IDX_W(IDX_W), .FRAC_W(FRAC_W), .SAMPLE_W(SAMPLE_W), .INTERP_LAT(NCO_INTERP_LAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .strobe(smp_stb), .phase_hi(phase_hi), .take(take),
    .rom_addr(rom_addr), .rom_data(rom_data), .taps(taps), .frac(frac),
    .taps_valid(taps_valid)
  );

  nco_sine_rom #(.ADDR_W(IDX_W), .DATA_W(SAMPLE_W), .AMP(NCO_AMPLITUDE)) u_rom (
    .clk(clk), .rd_addr(rom_addr), .rd_data(rom_data)
  );

  nco_cubic_interp #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_interp (
    .clk(clk), .rst_n(rst_n), .in_valid(taps_valid), .taps(taps), .frac(frac),
    .out_sample(smp_out), .out_valid(smp_valid)
  );

  // R8: the valid marker is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
endmodule

// File: tb/tb_sine_nco_interp.sv
`timescale 1ns/1ps
module tb_sine_nco_interp;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_stb = 1'b0;
  logic [31:0]        tune_word = '0;
  logic signed [15:0] smp_out;
  logic               smp_valid;

  sine_nco_interp dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .tune_word(tune_word),
    .smp_out(smp_out), .smp_valid(smp_valid)
  );

  always #2.5 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  typedef struct { int val; longint due; string tag; } exp_t;
  exp_t sb_q[$];
  exp_t cur;

  int sine_tbl[1024];
  logic [31:0] m_acc = '0;
  logic [31:0] m_step = '0;
  longint last_acc = -1000;

  function automatic int tbl_entry(int k);
    real x;
    x = 32767.0 * $sin(2.0 * 3.141592653589793 * real'(k) / 1024.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(0.5 - x);
  endfunction

  // Expected sample from R5, R6 and R7.
  function automatic int model_sample(logic [31:0] ph);
    int idx;
    longint t, q0, q1, q2, q3, a, b, c, d, h, y;
    idx = int'(ph[31:22]);
    t   = longint'(ph[21:6]);
    q0 = sine_tbl[(idx + 1023) % 1024];
    q1 = sine_tbl[idx];
    q2 = sine_tbl[(idx + 1) % 1024];
    q3 = sine_tbl[(idx + 2) % 1024];
    a = 3*q1 - 3*q2 + q3 - q0;
    b = 2*q0 - 5*q1 + 4*q2 - q3;
    c = q2 - q0;
    d = 2*q1;
    h = (a * t) >>> 16;
    h = ((b + h) * t) >>> 16;
    h = ((c + h) * t) >>> 16;
    y = (d + h + 1) >>> 1;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  task automatic check(string tag, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // Driver: one-cycle strobe, then junk on the tuning input (R4).
  task automatic send(input logic [31:0] tw, input int gap, input string tag);
    longint c;
    exp_t e;
    c = cyc;
    tune_word = tw;
    smp_stb = 1'b1;
    if (c - last_acc >= 10) begin
      e.val = model_sample(m_acc);
      e.due = c + 11;
      e.tag = tag;
      sb_q.push_back(e);
      m_acc = m_acc + m_step;
      m_step = tw;
      last_acc = c;
    end
    @(negedge clk);
    smp_stb = 1'b0;
    tune_word = ~tw ^ 32'h5A5A_1234;
    repeat (gap - 1) @(negedge clk);
  endtask

  // Three accepted strobes; the third samples exactly at target.
  task automatic aim(input logic [31:0] target, input string tag);
    logic [31:0] tw;
    tw = target - (m_acc + m_step);
    send(tw, 12, "R3 steer");
    send(32'h0, 12, "R3 steer");
    send(32'h0, 12, tag);
  endtask

  // Monitor: pops the scoreboard on every valid pulse.
  logic prev_v = 1'b0;
  logic signed [15:0] held = '0;
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (smp_valid) begin
        if (prev_v) check("R8 pulse width", 1, 0);
        if (sb_q.size() == 0) begin
          check("R2/R8 unexpected sample", 1, 0);
        end else begin
          cur = sb_q.pop_front();
          check({cur.tag, " value R7"}, smp_out, cur.val);
          check({cur.tag, " latency R8"}, cyc, cur.due);
        end
        held = smp_out;
      end else if (smp_out != held) begin
        check("R8 output hold", smp_out, held);
      end
      prev_v = smp_valid;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    for (int k = 0; k < 1024; k++) sine_tbl[k] = tbl_entry(k);
    repeat (4) @(negedge clk);
    check("R1 valid in reset", smp_valid, 0);
    check("R1 output in reset", smp_out, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", smp_valid, 0);
    check("R1 output after reset", smp_out, 0);

    // R1: first two samples sit at phase 0
    send(32'h0040_0000, 12, "R1 first");
    send(32'h0100_0000, 12, "R1 second");
    // R9: whole-index steps, zero fraction
    send(32'h0100_0000, 12, "R9 grid");
    send(32'h0040_0000, 12, "R9 grid");
    send(32'h0040_0000, 12, "R9 grid");
    // R3/R5: fractional steps
    send(32'h0012_3456, 12, "R3 frac");
    send(32'h00AB_CDEF, 12, "R3 frac");
    send(32'h0333_0001, 12, "R5 frac");
    // R2: strobe at the completion edge of the previous sample
    send(32'h0101_0101, 10, "R2 collide");
    send(32'h0202_0202, 10, "R2 collide");
    send(32'h0030_3030, 12, "R2 collide");
    // R2/R4: dropped strobe captures nothing
    send(32'h0040_0000, 5, "R2 before drop");
    send(32'h7777_7777, 12, "R2 drop");
    send(32'h0000_8000, 12, "R2/R4 after drop");
    send(32'h0010_0000, 12, "R2/R4 after drop");
    repeat (30) begin
      tune_word = tune_word + 32'h1357_9BDF;
      @(negedge clk);
    end
    send(32'h0020_0000, 12, "R4 idle junk");
    send(32'h0020_0000, 12, "R4 idle junk");
    // R6: wrap of the neighbour addresses
    aim(32'h0012_3440, "R6 low wrap");
    aim(32'h0000_0000, "R6 zero");
    aim(32'hFFFF_FFC0, "R6 top wrap");
    aim(32'hFF80_0000, "R6 slot 1022");
    aim(32'hFFBF_FFFF, "R6 slot 1022 frac");
    aim(32'hFFC0_0000, "R6 slot 1023");
    // R7: near the positive and negative peaks
    aim(32'h3FF0_0000, "R7 peak");
    aim(32'h4008_0000, "R7 peak");
    aim(32'hBFF4_0000, "R7 trough");
    // R3/R5: pseudo-random sweep with mixed spacing
    lcg = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      send(lcg, 10 + int'(lcg[3:0] % 5), "R3/R5 sweep");
    end
    repeat (20) @(negedge clk);
    check("R8 all samples emitted", sb_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule